// File: doc/BRIEF.md
# Link Controller Power-Up Reset Sequencer

This block takes a serial link controller and its PHY from full reset to operation in a fixed order. A bring-up request enables the clocks and lifts the PHY test power-down. After a mandatory settling gap it turns on the reference clock, so that the PHY's internally synchronised reset lasts long enough. It then waits for the clocks to settle and holds the external endpoint reset at its active level for a set time. Next it releases the endpoint reset and then the controller reset, polls the PHY PLL lock input a bounded number of times, and reports ready once a post-release settle time has passed.

A turn-off request from the ready state sends a turn-off pulse and then waits a fixed window. No acknowledge is checked. When the window ends, the clocks are gated and every output returns to the reset state. A bring-up request that arrives during turn-off is remembered and starts a new bring-up once turn-off has finished. If lock is never seen, the block falls back to full reset and holds an error flag until it is cleared. Every delay is a parameter counted in clock cycles.

Top module: `ctrl_pwrup_seq`

## Requirements
- R1: In the reset state `phyPwrDown`=1, `refClkEn`=0, `ctrlRst`=1, `clkEn`=0, `ready`=0, `turnOff`=0, and `epRst` is at its active level.
- R2: A `startReq` seen high in the reset state with no error raises `clkEn` and clears `phyPwrDown` in the next cycle. `refClkEn` rises after exactly PWR_GAP_CYC cycles with the PHY powered and the reference clock off.
- R3: After `refClkEn` rises, `epRst` stays active for STABLE_CYC + EP_HOLD_CYC cycles (clock settle followed by the endpoint hold) and then goes inactive.
- R4: The active level of `epRst` equals `epActiveHigh` (1 = active high, 0 = active low). The inactive level is its complement.
- R5: `ctrlRst` falls exactly one cycle after `epRst` goes inactive.
- R6: After `ctrlRst` falls, `lockIn` is sampled once every LOCK_GAP_CYC cycles, at the last cycle of each gap, for at most LOCK_TRIES samples. The first high sample ends the wait.
- R7: `ready` rises POST_REL_CYC cycles after the successful lock sample and stays high until a turn-off request.
- R8: If none of the LOCK_TRIES samples is high, the block returns to the reset state in the next cycle and sets `lockErr`. `lockErr` stays set until `errClear`, and `startReq` is ignored while it is set.
- R9: `offReq` in the ready state drops `ready`. `turnOff` is then high for OFF_PULSE_CYC cycles and low for OFF_WAIT_CYC cycles with the clocks still on. No acknowledge is checked. The block then returns to the reset state.
- R10: A `startReq` during turn-off is held. When turn-off ends, the reset state lasts one cycle and a bring-up follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Bring-up request |
| offReq | input | 1 | Turn-off request |
| lockIn | input | 1 | PHY PLL lock indication |
| epActiveHigh | input | 1 | Endpoint reset polarity, 1 = active high |
| errClear | input | 1 | Clears the lock error flag |
| phyPwrDown | output | 1 | PHY test power-down |
| refClkEn | output | 1 | Reference clock enable |
| clkEn | output | 1 | Controller and PHY clock enable |
| ctrlRst | output | 1 | Controller reset, active high |
| epRst | output | 1 | External endpoint reset |
| turnOff | output | 1 | Turn-off request pulse |
| ready | output | 1 | Link controller out of reset and locked |
| lockErr | output | 1 | Lock timeout error flag |

## Verification
The bench builds the block with short delays: a power gap of 3 cycles, settle 5, endpoint hold 4, lock gap 2, four lock tries, post-release 6, turn-off pulse 3 and turn-off wait 7. With these values every phase can be measured cycle by cycle, and a lock that arrives on the first, second or last permitted sample, or never, is reached within a few dozen cycles. The short turn-off window also makes it easy to land a bring-up request inside it, and to follow the error fallback through to its clearing.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_GAP, ST_STAB, ST_EPHOLD, ST_REL,
    ST_LOCK, ST_POST, ST_READY, ST_OFFPULSE, ST_OFFWAIT
  } seqState_e;

  typedef enum logic [2:0] {
    TM_GAP, TM_STAB, TM_EPHOLD, TM_LOCK, TM_POST, TM_OFFPULSE, TM_OFFWAIT
  } timerSel_e;

  typedef struct packed {
    logic      load;
    timerSel_e sel;
    logic      tryClr;
    logic      tryInc;
  } seqStrobe_t;

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrup_seq_dp.sv
module pwrup_seq_dp
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned PWR_GAP_CYC   = 1000,
  parameter int unsigned STABLE_CYC    = 20000,
  parameter int unsigned EP_HOLD_CYC   = 10000,
  parameter int unsigned LOCK_GAP_CYC  = 5000,
  parameter int unsigned LOCK_TRIES    = 2000,
  parameter int unsigned POST_REL_CYC  = 20000,
  parameter int unsigned OFF_PULSE_CYC = 2,
  parameter int unsigned OFF_WAIT_CYC  = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       timerDone,
  output logic       lastTry
);

  localparam int unsigned MAX_A = maxU(maxU(PWR_GAP_CYC, STABLE_CYC), maxU(EP_HOLD_CYC, LOCK_GAP_CYC));
  localparam int unsigned MAX_B = maxU(maxU(POST_REL_CYC, OFF_PULSE_CYC), OFF_WAIT_CYC);
  localparam int unsigned MAX_CYC = maxU(MAX_A, MAX_B);
  localparam int unsigned TW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam int unsigned RW = (LOCK_TRIES < 2) ? 1 : $clog2(LOCK_TRIES);

  logic [TW-1:0] cnt;
  logic [TW-1:0] loadVal;
  logic [RW-1:0] tryCnt;

  always_comb begin
    case (strb.sel)
      TM_GAP:      loadVal = TW'(PWR_GAP_CYC - 1);
      TM_STAB:     loadVal = TW'(STABLE_CYC - 1);
      TM_EPHOLD:   loadVal = TW'(EP_HOLD_CYC - 1);
      TM_LOCK:     loadVal = TW'(LOCK_GAP_CYC - 1);
      TM_POST:     loadVal = TW'(POST_REL_CYC - 1);
      TM_OFFPULSE: loadVal = TW'(OFF_PULSE_CYC - 1);
      TM_OFFWAIT:  loadVal = TW'(OFF_WAIT_CYC - 1);
      default:     loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tryCnt <= '0;
    end else if (strb.tryClr) begin
      tryCnt <= '0;
    end else if (strb.tryInc) begin
      tryCnt <= tryCnt + 1'b1;
    end
  end

  assign timerDone = (cnt == '0);
  assign lastTry   = (tryCnt == RW'(LOCK_TRIES - 1));

endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       offReq,
  input  logic       lockIn,
  input  logic       epActiveHigh,
  input  logic       errClear,
  input  logic       timerDone,
  input  logic       lastTry,
  output seqStrobe_t strb,
  output logic       phyPwrDown,
  output logic       refClkEn,
  output logic       clkEn,
  output logic       ctrlRst,
  output logic       epRst,
  output logic       turnOff,
  output logic       ready,
  output logic       lockErr
);

  seqState_e state, stateNext;
  logic      pendStart;
  logic      errSet;
  logic      startTaken;
  logic      epActive;

  always_comb begin
    stateNext  = state;
    strb       = '{load: 1'b0, sel: TM_GAP, tryClr: 1'b0, tryInc: 1'b0};
    errSet     = 1'b0;
    startTaken = 1'b0;
    case (state)
      ST_IDLE: begin
        if ((startReq || pendStart) && !lockErr) begin
          stateNext  = ST_GAP;
          strb.load  = 1'b1;
          strb.sel   = TM_GAP;
          startTaken = 1'b1;
        end
      end
      ST_GAP: begin
        if (timerDone) begin
          stateNext = ST_STAB;
          strb.load = 1'b1;
          strb.sel  = TM_STAB;
        end
      end
      ST_STAB: begin
        if (timerDone) begin
          stateNext = ST_EPHOLD;
          strb.load = 1'b1;
          strb.sel  = TM_EPHOLD;
        end
      end
      ST_EPHOLD: begin
        if (timerDone) stateNext = ST_REL;
      end
      ST_REL: begin
        stateNext   = ST_LOCK;
        strb.load   = 1'b1;
        strb.sel    = TM_LOCK;
        strb.tryClr = 1'b1;
      end
      ST_LOCK: begin
        if (timerDone) begin
          if (lockIn) begin
            stateNext = ST_POST;
            strb.load = 1'b1;
            strb.sel  = TM_POST;
          end else if (lastTry) begin
            stateNext = ST_IDLE;
            errSet    = 1'b1;
          end else begin
            strb.load   = 1'b1;
            strb.sel    = TM_LOCK;
            strb.tryInc = 1'b1;
          end
        end
      end
      ST_POST: begin
        if (timerDone) stateNext = ST_READY;
      end
      ST_READY: begin
        if (offReq) begin
          stateNext = ST_OFFPULSE;
          strb.load = 1'b1;
          strb.sel  = TM_OFFPULSE;
        end
      end
      ST_OFFPULSE: begin
        if (timerDone) begin
          stateNext = ST_OFFWAIT;
          strb.load = 1'b1;
          strb.sel  = TM_OFFWAIT;
        end
      end
      ST_OFFWAIT: begin
        if (timerDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendStart <= 1'b0;
      lockErr   <= 1'b0;
    end else begin
      state <= stateNext;
      if (startTaken) begin
        pendStart <= 1'b0;
      end else if (startReq && (state == ST_OFFPULSE || state == ST_OFFWAIT)) begin
        pendStart <= 1'b1;
      end
      if (errSet) begin
        lockErr <= 1'b1;
      end else if (errClear) begin
        lockErr <= 1'b0;
      end
    end
  end

  always_comb begin
    phyPwrDown = (state == ST_IDLE);
    clkEn      = (state != ST_IDLE);
    refClkEn   = (state != ST_IDLE) && (state != ST_GAP);
    ctrlRst    = (state == ST_IDLE) || (state == ST_GAP) || (state == ST_STAB) ||
                 (state == ST_EPHOLD) || (state == ST_REL);
    epActive   = (state == ST_IDLE) || (state == ST_GAP) || (state == ST_STAB) ||
                 (state == ST_EPHOLD);
    epRst      = epActive ? epActiveHigh : ~epActiveHigh;
    turnOff    = (state == ST_OFFPULSE);
    ready      = (state == ST_READY);
  end

endmodule

// File: rtl/ctrl_pwrup_seq.sv
module ctrl_pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int unsigned PWR_GAP_CYC   = 1000,
  parameter int unsigned STABLE_CYC    = 20000,
  parameter int unsigned EP_HOLD_CYC   = 10000,
  parameter int unsigned LOCK_GAP_CYC  = 5000,
  parameter int unsigned LOCK_TRIES    = 2000,
  parameter int unsigned POST_REL_CYC  = 20000,
  parameter int unsigned OFF_PULSE_CYC = 2,
  parameter int unsigned OFF_WAIT_CYC  = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic offReq,
  input  logic lockIn,
  input  logic epActiveHigh,
  input  logic errClear,
  output logic phyPwrDown,
  output logic refClkEn,
  output logic clkEn,
  output logic ctrlRst,
  output logic epRst,
  output logic turnOff,
  output logic ready,
  output logic lockErr
);

  seqStrobe_t strb;
  logic       timerDone;
  logic       lastTry;

  pwrup_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .offReq(offReq),
    .lockIn(lockIn), .epActiveHigh(epActiveHigh), .errClear(errClear),
    .timerDone(timerDone), .lastTry(lastTry), .strb(strb),
    .phyPwrDown(phyPwrDown), .refClkEn(refClkEn), .clkEn(clkEn),
    .ctrlRst(ctrlRst), .epRst(epRst), .turnOff(turnOff), .ready(ready),
    .lockErr(lockErr)
  );

  pwrup_seq_dp #(
    .PWR_GAP_CYC(PWR_GAP_CYC), .STABLE_CYC(STABLE_CYC), .EP_HOLD_CYC(EP_HOLD_CYC),
    .LOCK_GAP_CYC(LOCK_GAP_CYC), .LOCK_TRIES(LOCK_TRIES), .POST_REL_CYC(POST_REL_CYC),
    .OFF_PULSE_CYC(OFF_PULSE_CYC), .OFF_WAIT_CYC(OFF_WAIT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timerDone(timerDone), .lastTry(lastTry)
  );

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic clk,
  input logic rstN,
  input logic epActiveHigh,
  input logic errClear,
  input logic phyPwrDown,
  input logic refClkEn,
  input logic clkEn,
  input logic ctrlRst,
  input logic epRst,
  input logic turnOff,
  input logic ready,
  input logic lockErr
);

  assert_idle_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> (phyPwrDown && !refClkEn && ctrlRst && !ready && !turnOff));

  assert_refclk_powered_R2: assert property (@(posedge clk) disable iff (!rstN)
    refClkEn |-> !phyPwrDown);

  assert_release_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRst |-> (refClkEn && (epRst != epActiveHigh)));

  assert_ready_running_R7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (!ctrlRst && clkEn && !turnOff));

  assert_err_to_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockErr) |-> (ctrlRst && phyPwrDown && !refClkEn));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lockErr && !errClear) |=> lockErr);

  assert_off_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    turnOff |-> (!ready && !ctrlRst && clkEn));

endmodule

bind ctrl_pwrup_seq pwrup_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .epActiveHigh(epActiveHigh), .errClear(errClear),
  .phyPwrDown(phyPwrDown), .refClkEn(refClkEn), .clkEn(clkEn), .ctrlRst(ctrlRst),
  .epRst(epRst), .turnOff(turnOff), .ready(ready), .lockErr(lockErr)
);

// File: tb/tb_ctrl_pwrup_seq.sv
`timescale 1ns/1ps
module tb_ctrl_pwrup_seq;

  localparam int GAP = 3, STAB = 5, EPH = 4, LGAP = 2, TRIES = 4, POST = 6;
  localparam int OFFP = 3, OFFW = 7, LIM = 500;

  // vector: {lock delay in cycles after controller release, endpoint polarity}
  localparam int NVEC = 6;
  localparam logic [8:0] VECS [NVEC] = '{
    {8'd0, 1'b1}, {8'd1, 1'b0}, {8'd2, 1'b1},
    {8'd3, 1'b0}, {8'd8, 1'b1}, {8'd9, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, offReq = 1'b0, lockIn = 1'b0, epActiveHigh = 1'b1, errClear = 1'b0;
  logic phyPwrDown, refClkEn, clkEn, ctrlRst, epRst, turnOff, ready, lockErr;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ctrl_pwrup_seq #(
    .PWR_GAP_CYC(GAP), .STABLE_CYC(STAB), .EP_HOLD_CYC(EPH), .LOCK_GAP_CYC(LGAP),
    .LOCK_TRIES(TRIES), .POST_REL_CYC(POST), .OFF_PULSE_CYC(OFFP), .OFF_WAIT_CYC(OFFW)
  ) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .offReq(offReq), .lockIn(lockIn),
    .epActiveHigh(epActiveHigh), .errClear(errClear), .phyPwrDown(phyPwrDown),
    .refClkEn(refClkEn), .clkEn(clkEn), .ctrlRst(ctrlRst), .epRst(epRst),
    .turnOff(turnOff), .ready(ready), .lockErr(lockErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkIdle(input logic pol);
    chk("R1 reset state outputs", {phyPwrDown, refClkEn, ctrlRst, clkEn, ready, turnOff}, 6'b101000);
    chk("R4 endpoint reset active level", epRst, pol);
  endtask

  task automatic startPulse();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Entered at the negedge of the first power-gap cycle.
  task automatic followSeq(input int d, input logic pol);
    int n;
    int k;
    chk("R2 clocks on and PHY powered", {clkEn, phyPwrDown}, 2'b10);
    n = 0;
    while (!phyPwrDown && !refClkEn && n < LIM) begin n++; @(negedge clk); end
    chk("R2 power gap length", n, GAP);
    n = 0;
    while (refClkEn && epRst == pol && ctrlRst && n < LIM) begin n++; @(negedge clk); end
    chk("R3 settle plus endpoint hold", n, STAB + EPH);
    chk("R4 endpoint reset inactive level", epRst, !pol);
    n = 0;
    while (epRst != pol && ctrlRst && n < LIM) begin n++; @(negedge clk); end
    chk("R5 controller release delay", n, 1);
    n = 0;
    while (!ctrlRst && !ready && n < LIM) begin
      n++;
      lockIn = (n >= d);
      @(negedge clk);
    end
    lockIn = 1'b0;
    k = (d <= 0) ? 1 : (d + LGAP - 1) / LGAP;
    if (k <= TRIES) begin
      chk("R6 R7 lock sample and post settle", n, k * LGAP + POST);
      chk("R7 ready raised", ready, 1);
      repeat (3) @(negedge clk);
      chk("R7 ready held", ready, 1);
    end else begin
      chk("R6 R8 bounded lock tries", n, TRIES * LGAP);
      chk("R8 error flag", lockErr, 1);
      chkIdle(pol);
    end
  endtask

  task automatic turnOffSeq(input bit pend, input logic pol);
    int n;
    offReq = 1'b1;
    @(negedge clk);
    offReq = 1'b0;
    chk("R9 ready dropped", ready, 0);
    n = 0;
    while (turnOff && n < LIM) begin n++; @(negedge clk); end
    chk("R9 turn-off pulse length", n, OFFP);
    n = 0;
    while (!turnOff && clkEn && n < LIM) begin
      n++;
      startReq = (pend && n == 1);
      @(negedge clk);
    end
    startReq = 1'b0;
    chk("R9 turn-off wait without ack", n, OFFW);
    chkIdle(pol);
    if (pend) begin
      @(negedge clk);
      chk("R10 held request starts after one reset cycle", clkEn, 1);
    end else begin
      repeat (3) @(negedge clk);
      chk("R9 stays in reset after turn-off", clkEn, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle(1'b1);
    chk("R8 no error after reset", lockErr, 0);

    for (int i = 0; i < NVEC; i++) begin
      int d;
      logic pol;
      d = int'(VECS[i][8:1]);
      pol = VECS[i][0];
      epActiveHigh = pol;
      @(negedge clk);
      chkIdle(pol);
      startPulse();
      followSeq(d, pol);
      if (!lockErr) begin
        turnOffSeq(1'b0, pol);
      end
    end

    // Last vector ended in error: requests are ignored until cleared (R8)
    startPulse();
    repeat (3) @(negedge clk);
    chk("R8 start ignored while error set", {phyPwrDown, lockErr}, 2'b11);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk("R8 error cleared", lockErr, 0);
    chk("R8 still in reset after clear", phyPwrDown, 1);

    // Bring-up, then a request landing inside turn-off (R10)
    epActiveHigh = 1'b1;
    startPulse();
    followSeq(1, 1'b1);
    turnOffSeq(1'b1, 1'b1);
    followSeq(2, 1'b1);
    turnOffSeq(1'b0, 1'b1);

    // offReq outside ready has no effect on the reset state
    offReq = 1'b1;
    @(negedge clk);
    offReq = 1'b0;
    @(negedge clk);
    chk("R9 turn-off ignored in reset", turnOff, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule